// File: doc/BRIEF.md
# Segment-Folding Polynomial Remainder Unit

This unit takes a wide dividend in one parallel load and returns its modulo-2 remainder by a small generator polynomial. The generator must divide x^K + 1, where K is the segment width. Under that condition x^K is congruent to 1, so any K-bit slice of the dividend can be XORed into the slice just below it without changing the remainder. The unit repeats this fold until a single K-bit slice is left. A short bit-serial long division then reduces that slice by the true generator. A one-bit-per-cycle divider needs N cycles for an N-bit dividend; here each fold retires K bits.

The dividend is zero-padded on its most significant side up to a whole number of segments. A fold takes two cycles. In the first, the top segment is XORed into the adjacent lower one. In the second, the combined segment moves into the fold register and the rest shifts up one segment. A phase toggle selects between the two per-bit paths. The caller pulses start while the unit is idle and waits for the one-cycle done pulse. The residue then stays on its output until the next result. Reset is asserted asynchronously and released through a two-stage synchronizer.

Top module: `ozo_fold_crc`

## Requirements
- R1: While rst_n is low, and until the first accepted start after reset, done and busy are 0 and residue is 0.
- R2: The residue is the dividend modulo the generator. Dividend bit N-1 is the coefficient of x^(N-1), and residue bit j is the coefficient of x^j. The defaults are N=60, K=8 and generator x^3+x^2+x+1 (GPOLY=4'b1111, bit j = coefficient of x^j). As examples, dividend 0x10 gives 3'b001 and dividend x^59 gives 3'b111.
- R3: The done pulse follows the clock edge that accepts start by exactly 2*(ceil(N/K)-1)+K cycles, which is 22 cycles with the defaults.
- R4: done is high for exactly one cycle per accepted start.
- R5: busy is 1 in every cycle after the accepting edge and before done, and it is 0 in the cycle where done is 1.
- R6: A start pulse that arrives while busy is 1 is ignored. Neither the residue nor the timing of done changes.
- R7: Between done pulses, residue holds its value, even when the dividend input changes without a start.
- R8: When N is not a multiple of K, the missing top bits are treated as zeros. Dividends with bits set in the partial top segment still give the exact remainder.
- R9: When N equals K, no fold takes place. done follows the accepting edge by K cycles, and the residue is exact.
- R10: An all-zero dividend gives residue 0. An all-ones dividend with the defaults gives 0, because it holds fifteen groups of four ones and 1111 is the generator itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begin a division on the present dividend; taken only when busy is 0 |
| dividend | input | N | Parallel dividend, bit N-1 is the highest power |
| busy | output | 1 | A division is in progress |
| done | output | 1 | One-cycle pulse when residue is updated |
| residue | output | GDEG | Remainder, bit j is the coefficient of x^j |

## Verification
The checker's latency counter assumes that start is never raised in the two cycles after rst_n rises. The reset synchronizer is still holding the unit idle then, and a start there would restart the count on a request the unit does not see. The bench therefore waits several cycles after releasing reset before its first start. It drives start only on falling edges, for a single cycle, except in the deliberate busy-time start of R6. Expected remainders come from a bit-serial long division over the whole dividend. They are cross-checked against hand-derived values for x^4, x^59 and all-ones.

// File: rtl/ozo_crc_pkg.sv
`timescale 1ns/1ps
package ozo_crc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_FOLD   = 2'd1,
    ST_REDUCE = 2'd2
  } ozo_state_e;

endpackage

// File: rtl/ozo_fold_ctrl.sv
`timescale 1ns/1ps
module ozo_fold_ctrl
  import ozo_crc_pkg::*;
#(
  parameter int NSEG = 8,
  parameter int K    = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic phase,
  output logic load,
  output logic fold_en,
  output logic red_en,
  output logic finish,
  output logic busy
);

  localparam int FW = $clog2(NSEG + 1);
  localparam int CW = $clog2(K + 1);
  localparam logic [FW-1:0] FOLDS = FW'(NSEG - 1);
  localparam logic [CW-1:0] BITS  = CW'(K);

  ozo_state_e    state_q, state_d;
  logic [FW-1:0] fold_q, fold_d;
  logic [CW-1:0] bit_q, bit_d;

  always_comb begin
    state_d = state_q;
    fold_d  = fold_q;
    bit_d   = bit_q;
    load    = 1'b0;
    fold_en = 1'b0;
    red_en  = 1'b0;
    finish  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          load    = 1'b1;
          fold_d  = FOLDS;
          bit_d   = BITS;
          state_d = (NSEG > 1) ? ST_FOLD : ST_REDUCE;
        end
      end
      ST_FOLD: begin
        fold_en = 1'b1;
        if (phase) begin
          fold_d = fold_q - 1'b1;
          if (fold_q == FW'(1)) state_d = ST_REDUCE;
        end
      end
      ST_REDUCE: begin
        red_en = 1'b1;
        bit_d  = bit_q - 1'b1;
        if (bit_q == CW'(1)) begin
          finish  = 1'b1;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      fold_q  <= '0;
      bit_q   <= '0;
    end else begin
      state_q <= state_d;
      fold_q  <= fold_d;
      bit_q   <= bit_d;
    end
  end

  assign busy = (state_q != ST_IDLE);

endmodule

// File: rtl/ozo_fold_unit.sv
`timescale 1ns/1ps
module ozo_fold_unit #(
  parameter int K    = 8,
  parameter int NSEG = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic            fold_en,
  input  logic            shl_en,
  input  logic [NSEG*K-1:0] div_pad,
  output logic            phase,
  output logic            s_msb
);

  localparam int W  = NSEG * K;
  localparam int RW = (NSEG > 1) ? (NSEG - 1) * K : K;

  logic [K-1:0]  s_q, s_d;
  logic [RW-1:0] r_q, r_d, r_nx, r_init;
  logic          ph_q, ph_d;

  // Lower segments go to the remainder register; a single-segment
  // dividend leaves it empty.
  if (NSEG > 1) begin : g_rload
    assign r_init = div_pad[RW-1:0];
  end else begin : g_rzero
    assign r_init = '0;
  end

  // Per-bit path: phase 0 merges the fold segment into the top slice,
  // phase 1 moves every bit up by one segment.
  for (genvar i = 0; i < RW; i++) begin : g_rbit
    logic xor_v, shf_v;
    if (i >= RW - K) begin : g_top
      assign xor_v = r_q[i] ^ s_q[i-(RW-K)];
    end else begin : g_low
      assign xor_v = r_q[i];
    end
    if (i >= K) begin : g_up
      assign shf_v = r_q[i-K];
    end else begin : g_fill
      assign shf_v = 1'b0;
    end
    assign r_nx[i] = ph_q ? shf_v : xor_v;
  end

  always_comb begin
    r_d  = r_q;
    s_d  = s_q;
    ph_d = ph_q;
    if (load) begin
      r_d  = r_init;
      s_d  = div_pad[W-1 -: K];
      ph_d = 1'b0;
    end else if (fold_en) begin
      r_d  = r_nx;
      ph_d = ~ph_q;
      if (ph_q) s_d = r_q[RW-1 -: K];
    end else if (shl_en) begin
      s_d = s_q << 1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_q  <= '0;
      s_q  <= '0;
      ph_q <= 1'b0;
    end else begin
      r_q  <= r_d;
      s_q  <= s_d;
      ph_q <= ph_d;
    end
  end

  assign phase = ph_q;
  assign s_msb = s_q[K-1];

endmodule

// File: rtl/ozo_serial_reduce.sv
`timescale 1ns/1ps
module ozo_serial_reduce #(
  parameter int              GDEG  = 3,
  parameter logic [GDEG:0]   GPOLY = 4'b1111
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            step_en,
  input  logic            bit_in,
  output logic [GDEG-1:0] rem_step
);

  logic [GDEG-1:0] rem_q;
  logic [GDEG:0]   ext;

  // One long-division step: bring down a bit, subtract G if the
  // degree reaches that of G.
  always_comb begin
    ext = {rem_q, bit_in};
    if (ext[GDEG]) ext = ext ^ GPOLY;
    rem_step = ext[GDEG-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
    end else if (clr) begin
      rem_q <= '0;
    end else if (step_en) begin
      rem_q <= rem_step;
    end
  end

endmodule

// File: rtl/ozo_fold_crc.sv
`timescale 1ns/1ps
module ozo_fold_crc
  import ozo_crc_pkg::*;
#(
  parameter int            N     = 60,
  parameter int            K     = 8,
  parameter int            GDEG  = 3,
  parameter logic [GDEG:0] GPOLY = 4'b1111
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [N-1:0]    dividend,
  output logic            busy,
  output logic            done,
  output logic [GDEG-1:0] residue
);

  localparam int NSEG = (N + K - 1) / K;
  localparam int W    = NSEG * K;

  // x^K + 1 mod G must vanish for folding to preserve the remainder.
  function automatic logic gen_divides_ozo();
    logic [GDEG-1:0] r;
    logic [GDEG:0]   e;
    r = '0;
    for (int i = K; i >= 0; i--) begin
      e = {r, (i == K) || (i == 0)};
      if (e[GDEG]) e = e ^ GPOLY;
      r = e[GDEG-1:0];
    end
    return (r == '0);
  endfunction

  localparam logic GEN_OK = gen_divides_ozo();

  if (!GEN_OK) begin : g_bad_generator
    $error("generator does not divide x^K+1 for the chosen segment width");
  end

  logic [1:0]      rs_q;
  logic            rst_int_n;
  logic            load, fold_en, red_en, finish, phase, s_msb;
  logic [GDEG-1:0] rem_step;
  logic [W-1:0]    div_pad;
  logic            done_q, done_d;
  logic [GDEG-1:0] res_q, res_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_int_n = rs_q[1];

  assign div_pad = W'(dividend);

  ozo_fold_ctrl #(.NSEG(NSEG), .K(K)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .start   (start),
    .phase   (phase),
    .load    (load),
    .fold_en (fold_en),
    .red_en  (red_en),
    .finish  (finish),
    .busy    (busy)
  );

  ozo_fold_unit #(.K(K), .NSEG(NSEG)) u_fold (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .load    (load),
    .fold_en (fold_en),
    .shl_en  (red_en),
    .div_pad (div_pad),
    .phase   (phase),
    .s_msb   (s_msb)
  );

  ozo_serial_reduce #(.GDEG(GDEG), .GPOLY(GPOLY)) u_reduce (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .clr      (load),
    .step_en  (red_en),
    .bit_in   (s_msb),
    .rem_step (rem_step)
  );

  always_comb begin
    done_d = finish;
    res_d  = finish ? rem_step : res_q;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      done_q <= 1'b0;
      res_q  <= '0;
    end else begin
      done_q <= done_d;
      res_q  <= res_d;
    end
  end

  assign done    = done_q;
  assign residue = res_q;

endmodule

// File: rtl/ozo_fold_crc_chk.sv
`timescale 1ns/1ps
module ozo_fold_crc_chk #(
  parameter int N    = 60,
  parameter int K    = 8,
  parameter int GDEG = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start,
  input logic            busy,
  input logic            done,
  input logic [GDEG-1:0] residue
);

  localparam int NSEG = (N + K - 1) / K;
  localparam int LAT  = 2 * (NSEG - 1) + K;
  localparam int CW   = $clog2(LAT + 2);

  logic          run_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (start && !busy) begin
      run_q <= 1'b1;
      cnt_q <= '0;
    end else if (done) begin
      run_q <= 1'b0;
    end else if (run_q) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R3: done arrives a fixed number of cycles after the accepting edge
  p_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (run_q && cnt_q == CW'(LAT)));

  // R4: done lasts one cycle
  p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R5: busy is low when done is high and only drops together with done
  p_done_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  p_busy_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  p_busy_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  // R7: residue moves only with a done pulse
  p_res_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(residue));

  // R1: outputs cleared while reset is held
  p_reset_r1: assert property (@(posedge clk)
    !rst_n |-> (!done && !busy && residue == '0));

endmodule

bind ozo_fold_crc ozo_fold_crc_chk #(.N(N), .K(K), .GDEG(GDEG)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .start   (start),
  .busy    (busy),
  .done    (done),
  .residue (residue)
);

// File: tb/ozo_fold_crc_test.sv
`timescale 1ns/1ps
module ozo_fold_crc_test;

  localparam int MAIN_N   = 60;
  localparam int MAIN_LAT = 22;
  localparam int NK_LAT   = 8;

  logic        clk;
  logic        rst_n;
  logic        m_start, nk_start;
  logic [59:0] m_div;
  logic [7:0]  nk_div;
  logic        m_busy, m_done, nk_busy, nk_done;
  logic [2:0]  m_res, nk_res;

  int total = 0;
  int fails = 0;
  bit finished = 0;

  ozo_fold_crc uut (
    .clk(clk), .rst_n(rst_n), .start(m_start), .dividend(m_div),
    .busy(m_busy), .done(m_done), .residue(m_res)
  );

  ozo_fold_crc #(.N(8), .K(8), .GDEG(3), .GPOLY(4'b1111)) uut_nk (
    .clk(clk), .rst_n(rst_n), .start(nk_start), .dividend(nk_div),
    .busy(nk_busy), .done(nk_done), .residue(nk_res)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [2:0] ref_mod(input logic [63:0] d, input int n);
    logic [2:0] r;
    logic [3:0] e;
    r = '0;
    for (int i = n - 1; i >= 0; i--) begin
      e = {r, d[i]};
      if (e[3]) e = e ^ 4'b1111;
      r = e[2:0];
    end
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic run_one(input bit nk, input logic [63:0] d, input string tag,
                         input bit intrude, input logic [63:0] d2);
    int cnt;
    int lat;
    bit busy_bad;
    logic [2:0] exp;
    logic [2:0] got;
    exp = ref_mod(d, nk ? 8 : MAIN_N);
    lat = nk ? NK_LAT : MAIN_LAT;
    @(negedge clk);
    if (nk) begin nk_div = d[7:0]; nk_start = 1'b1; end
    else    begin m_div = d[59:0]; m_start = 1'b1; end
    @(negedge clk);
    m_start = 1'b0;
    nk_start = 1'b0;
    cnt = 0;
    busy_bad = 0;
    while (cnt < 64) begin
      @(negedge clk);
      cnt++;
      if (intrude && cnt == 5) begin m_div = d2[59:0]; m_start = 1'b1; end
      if (intrude && cnt == 6) m_start = 1'b0;
      if (nk ? nk_done : m_done) break;
      if (!(nk ? nk_busy : m_busy)) busy_bad = 1;
    end
    got = nk ? nk_res : m_res;
    check(cnt == lat, nk ? "R9" : "R3", {tag, " latency"}, cnt, lat);
    check(got == exp, nk ? "R9" : "R2", {tag, " residue"}, got, exp);
    check(!busy_bad, "R5", {tag, " busy during run"}, busy_bad, 0);
    check((nk ? nk_busy : m_busy) == 1'b0, "R5", {tag, " busy at done"},
          nk ? nk_busy : m_busy, 0);
    @(negedge clk);
    check((nk ? nk_done : m_done) == 1'b0, "R4", {tag, " done width"},
          nk ? nk_done : m_done, 0);
    check((nk ? nk_res : m_res) == exp, "R7", {tag, " residue after done"},
          nk ? nk_res : m_res, exp);
  endtask

  task automatic t_reset();
    rst_n = 1'b1;
    m_start = 1'b0; nk_start = 1'b0;
    m_div = '0; nk_div = '0;
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(!m_done && !m_busy && m_res == 3'd0, "R1", "main during reset",
          {m_done, m_busy, m_res}, 0);
    check(!nk_done && !nk_busy && nk_res == 3'd0, "R1", "nk during reset",
          {nk_done, nk_busy, nk_res}, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(!m_done && !m_busy && m_res == 3'd0, "R1", "main after release",
          {m_done, m_busy, m_res}, 0);
  endtask

  task automatic t_known();
    run_one(0, 64'h10, "x^4", 0, 0);
    check(m_res == 3'b001, "R2", "x^4 hand value", m_res, 3'b001);
    run_one(0, 64'h1 << 59, "x^59", 0, 0);
    check(m_res == 3'b111, "R8", "x^59 hand value", m_res, 3'b111);
    run_one(0, 64'hA5 << 52, "top partial segment", 0, 0);
    run_one(0, 64'h0FED_CBA9_8765_4321, "mixed", 0, 0);
  endtask

  task automatic t_edges();
    run_one(0, 64'h0, "all zero", 0, 0);
    check(m_res == 3'b000, "R10", "all zero residue", m_res, 0);
    run_one(0, 64'h0FFF_FFFF_FFFF_FFFF, "all ones", 0, 0);
    check(m_res == 3'b000, "R10", "all ones residue", m_res, 0);
  endtask

  task automatic t_random();
    for (int k = 0; k < 20; k++) begin
      run_one(0, {$urandom(), $urandom()}, "random", 0, 0);
    end
  endtask

  task automatic t_ignore();
    run_one(0, 64'h1, "start while busy", 1, 64'h3);
    check(m_res == 3'b001, "R6", "busy start ignored", m_res, 3'b001);
  endtask

  task automatic t_hold();
    logic [2:0] keep;
    bit saw_done;
    run_one(0, 64'h0123_4567_89AB_CDEF, "hold base", 0, 0);
    keep = m_res;
    saw_done = 0;
    m_div = 60'h5;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      if (m_done) saw_done = 1;
    end
    check(m_res == keep, "R7", "residue after idle input change", m_res, keep);
    check(!saw_done, "R7", "no done without start", saw_done, 0);
  endtask

  task automatic t_nk();
    run_one(1, 64'h00, "N=K zero", 0, 0);
    run_one(1, 64'hFF, "N=K ones", 0, 0);
    check(nk_res == 3'b000, "R9", "N=K all ones hand value", nk_res, 0);
    run_one(1, 64'h10, "N=K x^4", 0, 0);
    check(nk_res == 3'b001, "R9", "N=K x^4 hand value", nk_res, 3'b001);
    for (int k = 0; k < 6; k++) begin
      run_one(1, 64'($urandom() & 32'hFF), "N=K random", 0, 0);
    end
  endtask

  initial begin
    t_reset();
    t_known();
    t_edges();
    t_random();
    t_ignore();
    t_hold();
    t_nk();
    finished = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

endmodule